// File: doc/BRIEF.md
# Prioritized Nested Event Controller

This block arbitrates sixteen prioritized core event levels. Level 0 has the highest priority and level 15 the lowest. Level 0 is emulation, 1 is reset, 2 is the non-maskable interrupt, 3 is the exception level and 4 is the global-disable flag. Level 5 is hardware error, level 6 is the core timer, and levels 7 to 15 are general purpose.

Requests come from per-level input lines or from a single raise strobe that carries a level number. Each request sets a bit in a latch register. The controller tracks the levels being serviced in an in-service register. Bit 4 of that register works as a global interrupt disable, not as a level.

Every cycle, the controller compares the most urgent latched and enabled request with the level being serviced. It then either takes the event, reports a double fault, or leaves the request latched. A taken event appears one cycle later as a take strobe. The strobe carries the level and a flag that says whether the reset vector replaces the level's own vector. Return strobes and the global-disable set and clear strobes change the in-service register, and arbitration runs again on the following cycle.

Software reaches five 32-bit registers through a register port. Only full-word accesses take effect.

Top module: `nested_evt_ctrl`

## Requirements
- R1: After reset, the mask register reads 0x0000001F, the in-service register reads 0x00000012, the latch register reads 0, and no take or double-fault strobe is active.
- R2: A mask write keeps bits 0 to 4 at 1 and stores bits 5 to 15 from the data. A priority write keeps only data bits 0 to 4. The override register stores data bits 0 to 15. Register offsets are: override 0x00, mask 0x04, in-service 0x08, latch 0x0C, priority 0x10.
- R3: Bus writes to the in-service register have no effect. Any access whose byte enables are not all four set also has no effect.
- R4: A request sets the latch bit of its level, except that level-4 requests are ignored. A latch write clears each bit written as 1 under the mask 0xFFEE.
- R5: The current level is the lowest set bit of the in-service register, ignoring bits 0 and 4. With no such bit, the current level output reads 16 (user level).
- R6: The candidate is the lowest set bit of (latch AND mask). It is taken if its number is lower than the current level, or equal to it while self-nesting is enabled. The take strobe appears one cycle after the latch bit is visible. Taking sets the level's in-service bit and clears its latch bit.
- R7: Levels 0 and 1 are always taken. A candidate at level 2 or 3 whose number is not lower than the current level produces a one-cycle double-fault strobe instead. Its latch bit is cleared and the in-service register is unchanged.
- R8: A candidate at level 5 or above is not taken while in-service bit 4 is set and the core is not at user level. It is also not taken while its mask bit is clear. In both cases it stays latched and is taken once the block is removed.
- R9: Taking a level of 5 or above also sets in-service bit 4.
- R10: A return strobe clears the in-service bit of its level. A return from level 1 or from level 5 or above also clears bit 4.
- R11: The take strobe's reset-vector flag is 1 exactly when the taken level is 7 or above and its override bit is set.
- R12: The disable-set strobe sets in-service bit 4 and the disable-clear strobe clears it. Arbitration reflects the change on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 5 | Byte address of the register access |
| regByteEn | input | 4 | Byte enables; only 4'hF takes effect |
| regWrite | input | 1 | Write strobe |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |
| levelReq | input | 16 | Per-level request lines |
| raiseValid | input | 1 | Raise strobe (exception or software raise) |
| raiseLevel | input | 4 | Level raised by raiseValid |
| retValid | input | 1 | Return-from-event strobe |
| retLevel | input | 4 | Level being returned from |
| irqDisSet | input | 1 | Set the global disable bit |
| irqDisClr | input | 1 | Clear the global disable bit |
| selfNestEn | input | 1 | Allow re-entry at the current level |
| takeValid | output | 1 | Event taken this cycle |
| takeLevel | output | 4 | Level of the taken event or double fault |
| takeResetVec | output | 1 | Use the reset vector for the taken event |
| doubleFault | output | 1 | Double-fault strobe |
| curLevel | output | 5 | Current level, 16 at user level |

## Verification
The hardest case to reach is a request that sits blocked in the latch and is then taken because of a state change rather than a new request. Three such changes are a mask write, a clear of the global-disable bit, and turning on self-nesting at the level already in service. The directed sequence first leaves reset level by returning from level 1. It then builds real nesting: it takes level 9, leaves a level-7 request blocked by the disable bit, and releases it with a disable-clear strobe. It also re-raises level 9 while level 9 is still in service. Double faults are provoked by raising level 3 while level 3 is in service. The same nest is then deepened with levels 2 and 0.

// File: rtl/nested_evt_pkg.sv
package nested_evt_pkg;
  localparam int NUM_LEVELS = 16;
  localparam int LVL_W      = 4;
  localparam int GDIS_BIT   = 4;
  localparam int NUM_UNMASK = 5;
  localparam int FIRST_GP   = 7;
  localparam int FIRST_IRQ  = 5;

  localparam logic [2:0] OFS_OVR  = 3'd0;
  localparam logic [2:0] OFS_MASK = 3'd1;
  localparam logic [2:0] OFS_PEND = 3'd2;
  localparam logic [2:0] OFS_LAT  = 3'd3;
  localparam logic [2:0] OFS_PRIO = 3'd4;

  typedef struct packed {
    logic             take;
    logic             dfault;
    logic [LVL_W-1:0] lvl;
  } ctrlStrb_t;
endpackage

// File: rtl/nested_evt_arb.sv
module nested_evt_arb
  import nested_evt_pkg::*;
(
  input  logic [NUM_LEVELS-1:0] latchQ,
  input  logic [NUM_LEVELS-1:0] maskQ,
  input  logic [NUM_LEVELS-1:0] pendQ,
  input  logic                  selfNestEn,
  output ctrlStrb_t             strb,
  output logic [LVL_W:0]        curLvl
);
  localparam logic [NUM_LEVELS-1:0] IGNORE_CUR = NUM_LEVELS'((1 << 0) | (1 << GDIS_BIT));
  localparam logic [NUM_LEVELS-1:0] NO_GDIS    = ~NUM_LEVELS'(1 << GDIS_BIT);

  logic [NUM_LEVELS-1:0] candVec, curVec;
  logic                  candValid, atUser, gdisBlock;
  logic [LVL_W-1:0]      candLvl;

  always_comb begin
    candVec   = latchQ & maskQ & NO_GDIS;
    curVec    = pendQ & ~IGNORE_CUR;
    candValid = |candVec;
    candLvl   = '0;
    curLvl    = (LVL_W+1)'(NUM_LEVELS);
    for (int i = NUM_LEVELS-1; i >= 0; i--) begin
      if (candVec[i]) candLvl = LVL_W'(i);
      if (curVec[i])  curLvl  = (LVL_W+1)'(i);
    end
  end

  assign atUser    = (curLvl == (LVL_W+1)'(NUM_LEVELS));
  assign gdisBlock = pendQ[GDIS_BIT] && !atUser;

  always_comb begin
    strb.take   = 1'b0;
    strb.dfault = 1'b0;
    strb.lvl    = candLvl;
    if (candValid) begin
      if (candLvl <= LVL_W'(1)) begin
        strb.take = 1'b1;
      end else if (candLvl < LVL_W'(GDIS_BIT)) begin
        if ({1'b0, candLvl} < curLvl) strb.take = 1'b1;
        else                          strb.dfault = 1'b1;
      end else if (!gdisBlock) begin
        if ({1'b0, candLvl} < curLvl || (selfNestEn && {1'b0, candLvl} == curLvl))
          strb.take = 1'b1;
      end
    end
  end
endmodule

// File: rtl/nested_evt_regs.sv
module nested_evt_regs
  import nested_evt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [3:0]            regByteEn,
  input  logic                  regWrite,
  input  logic [DATA_W-1:0]     regWdata,
  output logic [DATA_W-1:0]     regRdata,
  input  logic [NUM_LEVELS-1:0] levelReq,
  input  logic                  raiseValid,
  input  logic [LVL_W-1:0]      raiseLevel,
  input  logic                  retValid,
  input  logic [LVL_W-1:0]      retLevel,
  input  logic                  irqDisSet,
  input  logic                  irqDisClr,
  input  ctrlStrb_t             strb,
  output logic [NUM_LEVELS-1:0] latchQ,
  output logic [NUM_LEVELS-1:0] maskQ,
  output logic [NUM_LEVELS-1:0] pendQ,
  output logic                  takeValidQ,
  output logic [LVL_W-1:0]      evtLvlQ,
  output logic                  takeResetVecQ,
  output logic                  doubleFaultQ
);
  localparam logic [NUM_LEVELS-1:0] UNMASK    = NUM_LEVELS'((1 << NUM_UNMASK) - 1);
  localparam logic [NUM_LEVELS-1:0] GDIS_M    = NUM_LEVELS'(1 << GDIS_BIT);
  localparam logic [NUM_LEVELS-1:0] W1C_MASK  = ~(NUM_LEVELS'(1) | GDIS_M);
  localparam logic [NUM_LEVELS-1:0] PEND_RST  = NUM_LEVELS'(2) | GDIS_M;
  localparam logic [NUM_LEVELS-1:0] GP_M      = ~NUM_LEVELS'((1 << FIRST_GP) - 1);

  logic [NUM_LEVELS-1:0] ovrQ, prioQ;
  logic [NUM_LEVELS-1:0] reqVec, takeVec, retVec, w1cVec, wdLo;
  logic                  wrOk;
  logic [2:0]            wordSel;

  assign wordSel = regAddr[4:2];
  assign wrOk    = regWrite && (regByteEn == 4'hF) && (regAddr[1:0] == 2'b00);
  assign wdLo    = regWdata[NUM_LEVELS-1:0];

  always_comb begin
    reqVec  = levelReq & ~GDIS_M;
    if (raiseValid && raiseLevel != LVL_W'(GDIS_BIT))
      reqVec[raiseLevel] = 1'b1;
    takeVec = '0;
    if (strb.take || strb.dfault) takeVec[strb.lvl] = 1'b1;
    retVec  = '0;
    if (retValid && retLevel != LVL_W'(GDIS_BIT)) begin
      retVec[retLevel] = 1'b1;
      if (retLevel >= LVL_W'(FIRST_IRQ) || retLevel == LVL_W'(1)) retVec[GDIS_BIT] = 1'b1;
    end
    w1cVec  = (wrOk && wordSel == OFS_LAT) ? (wdLo & W1C_MASK) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovrQ          <= '0;
      maskQ         <= UNMASK;
      pendQ         <= PEND_RST;
      latchQ        <= '0;
      prioQ         <= '0;
      takeValidQ    <= 1'b0;
      evtLvlQ       <= '0;
      takeResetVecQ <= 1'b0;
      doubleFaultQ  <= 1'b0;
    end else begin
      if (wrOk && wordSel == OFS_OVR)  ovrQ  <= wdLo;
      if (wrOk && wordSel == OFS_MASK) maskQ <= (wdLo & ~UNMASK) | UNMASK;
      if (wrOk && wordSel == OFS_PRIO) prioQ <= wdLo & UNMASK;
      latchQ <= (latchQ & ~takeVec & ~w1cVec) | reqVec;
      pendQ  <= (pendQ & ~retVec & ~(irqDisClr ? GDIS_M : '0))
              | (strb.take ? (takeVec | ((strb.lvl >= LVL_W'(FIRST_IRQ)) ? GDIS_M : '0)) : '0)
              | (irqDisSet ? GDIS_M : '0);
      takeValidQ    <= strb.take;
      doubleFaultQ  <= strb.dfault;
      evtLvlQ       <= strb.lvl;
      takeResetVecQ <= strb.take && ((ovrQ & GP_M & takeVec) != '0);
    end
  end

  always_comb begin
    regRdata = '0;
    if (regByteEn == 4'hF && regAddr[1:0] == 2'b00) begin
      case (wordSel)
        OFS_OVR:  regRdata = DATA_W'(ovrQ);
        OFS_MASK: regRdata = DATA_W'(maskQ);
        OFS_PEND: regRdata = DATA_W'(pendQ);
        OFS_LAT:  regRdata = DATA_W'(latchQ);
        OFS_PRIO: regRdata = DATA_W'(prioQ);
        default:  regRdata = '0;
      endcase
    end
  end

  assert_take_marks_service_R9: assert property (@(posedge clk) disable iff (!rstN)
    takeValidQ |-> pendQ[evtLvlQ] && (evtLvlQ < LVL_W'(FIRST_IRQ) || pendQ[GDIS_BIT]));
  assert_reset_vec_range_R11: assert property (@(posedge clk) disable iff (!rstN)
    takeResetVecQ |-> takeValidQ && evtLvlQ >= LVL_W'(FIRST_GP));
  assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({takeValidQ, doubleFaultQ}));
  assert_mask_honoured_R8: assert property (@(posedge clk) disable iff (!rstN)
    takeValidQ |-> (($past(maskQ) >> evtLvlQ) & NUM_LEVELS'(1)) != '0);
  assert_unmaskable_kept_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(wrOk) |-> &maskQ[NUM_UNMASK-1:0]);
endmodule

// File: rtl/nested_evt_ctrl.sv
module nested_evt_ctrl
  import nested_evt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [3:0]            regByteEn,
  input  logic                  regWrite,
  input  logic [DATA_W-1:0]     regWdata,
  output logic [DATA_W-1:0]     regRdata,
  input  logic [NUM_LEVELS-1:0] levelReq,
  input  logic                  raiseValid,
  input  logic [LVL_W-1:0]      raiseLevel,
  input  logic                  retValid,
  input  logic [LVL_W-1:0]      retLevel,
  input  logic                  irqDisSet,
  input  logic                  irqDisClr,
  input  logic                  selfNestEn,
  output logic                  takeValid,
  output logic [LVL_W-1:0]      takeLevel,
  output logic                  takeResetVec,
  output logic                  doubleFault,
  output logic [LVL_W:0]        curLevel
);
  ctrlStrb_t             strb;
  logic [NUM_LEVELS-1:0] latchQ, maskQ, pendQ;

  nested_evt_arb uArb (
    .latchQ(latchQ), .maskQ(maskQ), .pendQ(pendQ), .selfNestEn(selfNestEn),
    .strb(strb), .curLvl(curLevel)
  );

  nested_evt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uRegs (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regByteEn(regByteEn),
    .regWrite(regWrite), .regWdata(regWdata), .regRdata(regRdata),
    .levelReq(levelReq), .raiseValid(raiseValid), .raiseLevel(raiseLevel),
    .retValid(retValid), .retLevel(retLevel), .irqDisSet(irqDisSet),
    .irqDisClr(irqDisClr), .strb(strb), .latchQ(latchQ), .maskQ(maskQ),
    .pendQ(pendQ), .takeValidQ(takeValid), .evtLvlQ(takeLevel),
    .takeResetVecQ(takeResetVec), .doubleFaultQ(doubleFault)
  );
endmodule

// File: tb/tb_nested_evt_ctrl.sv
module tb_nested_evt_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [3:0]  regByteEn = 4'hF;
  logic        regWrite = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [15:0] levelReq = '0;
  logic        raiseValid = 1'b0;
  logic [3:0]  raiseLevel = '0;
  logic        retValid = 1'b0;
  logic [3:0]  retLevel = '0;
  logic        irqDisSet = 1'b0;
  logic        irqDisClr = 1'b0;
  logic        selfNestEn = 1'b0;
  logic        takeValid, takeResetVec, doubleFault;
  logic [3:0]  takeLevel;
  logic [4:0]  curLevel;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  localparam logic [4:0] A_OVR = 5'h00, A_MASK = 5'h04, A_PEND = 5'h08,
                         A_LAT = 5'h0C, A_PRIO = 5'h10;

  always #5 clk = ~clk;

  nested_evt_ctrl dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regByteEn(regByteEn),
    .regWrite(regWrite), .regWdata(regWdata), .regRdata(regRdata),
    .levelReq(levelReq), .raiseValid(raiseValid), .raiseLevel(raiseLevel),
    .retValid(retValid), .retLevel(retLevel), .irqDisSet(irqDisSet),
    .irqDisClr(irqDisClr), .selfNestEn(selfNestEn), .takeValid(takeValid),
    .takeLevel(takeLevel), .takeResetVec(takeResetVec),
    .doubleFault(doubleFault), .curLevel(curLevel)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regWr(logic [4:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
    @(negedge clk);
    regAddr = a; regWdata = d; regByteEn = be; regWrite = 1'b1;
    @(negedge clk);
    regWrite = 1'b0; regByteEn = 4'hF;
  endtask

  task automatic regRd(logic [4:0] a, output logic [31:0] d);
    regAddr = a; regByteEn = 4'hF;
    #1 d = regRdata;
  endtask

  task automatic readCheck(string req, logic [4:0] a, logic [31:0] exp);
    logic [31:0] d;
    regRd(a, d);
    check(req, d, exp);
  endtask

  // Pulse a raise; returns at the negedge where a take for it would be visible.
  task automatic raise(logic [3:0] lvl);
    @(negedge clk);
    raiseValid = 1'b1; raiseLevel = lvl;
    @(negedge clk);
    raiseValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic doReturn(logic [3:0] lvl);
    @(negedge clk);
    retValid = 1'b1; retLevel = lvl;
    @(negedge clk);
    retValid = 1'b0;
  endtask

  task automatic expectTake(string req, logic [3:0] lvl, logic rv);
    check({req, " take"}, 32'(takeValid), 32'd1);
    check({req, " level"}, 32'(takeLevel), 32'(lvl));
    check({req, " resetvec"}, 32'(takeResetVec), 32'(rv));
  endtask

  task automatic expectNone(string req);
    check({req, " no take"}, 32'(takeValid), 32'd0);
    check({req, " no dfault"}, 32'(doubleFault), 32'd0);
  endtask

  task automatic tResetState();
    readCheck("R1 mask", A_MASK, 32'h1F);
    readCheck("R1 pend", A_PEND, 32'h12);
    readCheck("R1 latch", A_LAT, 32'h0);
    expectNone("R1");
    check("R5 cur at reset", 32'(curLevel), 32'd1);
  endtask

  task automatic tRegisters();
    regWr(A_MASK, 32'h0);
    readCheck("R2 mask low kept", A_MASK, 32'h1F);
    regWr(A_MASK, 32'hFFFF_FFFF);
    readCheck("R2 mask full", A_MASK, 32'hFFFF);
    regWr(A_PRIO, 32'hFFFF_FFFF);
    readCheck("R2 prio", A_PRIO, 32'h1F);
    regWr(A_OVR, 32'h1234_5678);
    readCheck("R2 override", A_OVR, 32'h5678);
    regWr(A_OVR, 32'h0);
    regWr(A_PEND, 32'h0);
    readCheck("R3 pend readonly", A_PEND, 32'h12);
    regWr(A_MASK, 32'h001F, 4'h3);
    readCheck("R3 partial write", A_MASK, 32'hFFFF);
  endtask

  task automatic tLeaveReset();
    doReturn(4'd1);
    readCheck("R10 ret lvl1", A_PEND, 32'h0);
    check("R5 user", 32'(curLevel), 32'd16);
  endtask

  task automatic tMaskRelease();
    regWr(A_MASK, 32'h1F);
    raise(4'd9);
    expectNone("R8 masked");
    readCheck("R8 stays latched", A_LAT, 32'h200);
    @(negedge clk);
    regAddr = A_MASK; regWdata = 32'hFFFF; regWrite = 1'b1;
    @(negedge clk);
    regWrite = 1'b0;
    @(negedge clk);
    expectTake("R6 mask release", 4'd9, 1'b0);
    readCheck("R9 pend", A_PEND, 32'h210);
    readCheck("R6 latch cleared", A_LAT, 32'h0);
    check("R5 cur 9", 32'(curLevel), 32'd9);
  endtask

  task automatic tGlobalDisable();
    raise(4'd7);
    expectNone("R8 gdis block");
    readCheck("R8 latched 7", A_LAT, 32'h80);
    @(negedge clk);
    irqDisClr = 1'b1;
    @(negedge clk);
    irqDisClr = 1'b0;
    @(negedge clk);
    expectTake("R12 release", 4'd7, 1'b0);
    readCheck("R12 pend", A_PEND, 32'h290);
    doReturn(4'd7);
    readCheck("R10 ret 7", A_PEND, 32'h200);
    check("R5 back 9", 32'(curLevel), 32'd9);
  endtask

  task automatic tSelfNest();
    raise(4'd9);
    expectNone("R6 no selfnest");
    readCheck("R6 latched 9", A_LAT, 32'h200);
    @(negedge clk);
    selfNestEn = 1'b1;
    @(negedge clk);
    expectTake("R6 selfnest", 4'd9, 1'b0);
    selfNestEn = 1'b0;
    readCheck("R9 pend nest", A_PEND, 32'h210);
    doReturn(4'd9);
    readCheck("R10 ret 9", A_PEND, 32'h0);
    check("R5 user again", 32'(curLevel), 32'd16);
    @(negedge clk);
    irqDisSet = 1'b1;
    @(negedge clk);
    irqDisSet = 1'b0;
    readCheck("R12 set", A_PEND, 32'h10);
    @(negedge clk);
    irqDisClr = 1'b1;
    @(negedge clk);
    irqDisClr = 1'b0;
    readCheck("R12 clr", A_PEND, 32'h0);
  endtask

  task automatic tDoubleFault();
    raise(4'd3);
    expectTake("R6 exception", 4'd3, 1'b0);
    readCheck("R7 pend 3", A_PEND, 32'h8);
    raise(4'd3);
    check("R7 dfault", 32'(doubleFault), 32'd1);
    check("R7 no take", 32'(takeValid), 32'd0);
    readCheck("R7 pend kept", A_PEND, 32'h8);
    readCheck("R7 latch cleared", A_LAT, 32'h0);
    raise(4'd2);
    expectTake("R7 nmi over exc", 4'd2, 1'b0);
    raise(4'd0);
    expectTake("R7 emu always", 4'd0, 1'b0);
    readCheck("R7 pend 0,2,3", A_PEND, 32'hD);
    check("R5 ignores bit0", 32'(curLevel), 32'd2);
    doReturn(4'd0);
    doReturn(4'd2);
    doReturn(4'd3);
    readCheck("R10 all returned", A_PEND, 32'h0);
  endtask

  task automatic tLatchW1C();
    regWr(A_MASK, 32'hEFFF);
    @(negedge clk);
    levelReq = 16'h1010;
    @(negedge clk);
    levelReq = '0;
    @(negedge clk);
    expectNone("R4 masked line");
    readCheck("R4 lvl4 ignored", A_LAT, 32'h1000);
    regWr(A_LAT, 32'hFFFF_FFFF);
    readCheck("R4 w1c", A_LAT, 32'h0);
    regWr(A_MASK, 32'hFFFF);
  endtask

  task automatic tOverride();
    regWr(A_OVR, 32'h0800);
    raise(4'd11);
    expectTake("R11 override", 4'd11, 1'b1);
    doReturn(4'd11);
    regWr(A_OVR, 32'hFFFF);
    raise(4'd6);
    expectTake("R11 below range", 4'd6, 1'b0);
    doReturn(4'd6);
    readCheck("R10 final", A_PEND, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tResetState();
    tRegisters();
    tLeaveReset();
    tMaskRelease();
    tGlobalDisable();
    tSelfNest();
    tDoubleFault();
    tLatchW1C();
    tOverride();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule